// File: doc/BRIEF.md
# Prescaled Timer/Counter with Atomic Wide Access

This block is an up-counter that runs as either an 8-bit or a 16-bit register. It advances on one of two sources: the internal instruction-cycle tick, which fires once every four system clocks, or a chosen edge of an external pin. A 3-bit division field can put a power-of-two divider in front of the counter, and a separate bit bypasses that divider. When the counter rolls over it sets an overflow flag. That flag is the only notification the block provides.

Software reaches the block through a byte-wide register bus with four addresses: count low byte, high-byte holding register, control, and flag.

In wide mode the true upper byte has no bus address of its own. Reading the low byte copies the upper byte into the holding register during the same access, so a later read of the holding register returns a value that matches the low byte already read. Writing the low byte loads the upper byte from the holding register, so all sixteen bits change on one edge. Any write to the low byte also holds off counting for the next two instruction ticks and clears the divider's partial count.

Top module: `tmr_unit`

## Requirements
- R1: After reset, control (address 2) reads 0xA7, count low (address 0), holding register (address 1) and flag (address 3) read 0x00, and `ovf_flag` is low. Control bits: 7 run, 6 wide mode, 5 external source, 4 falling edge, 3 divider bypass, 2:0 division field.
- R2: With the internal source and bypass set, the count rises by one on each instruction tick. Instruction ticks arrive every 4 system clocks.
- R3: With bypass clear, the count rises once per 2^(field+1) source events, giving ratios from 1:2 up to 1:256.
- R4: With the external source, the count follows pin edges after a two-flop synchronizer. Edge bit 0 counts rising edges and edge bit 1 counts falling edges.
- R5: A write to address 0 suppresses the next two instruction ticks' worth of source events and clears the divider's partial count.
- R6: In wide mode, a read access to address 0 copies the true upper byte into the holding register on that edge.
- R7: Writing address 1 changes only the holding register. In wide mode, writing address 0 loads the counter with {holding register, data} in one edge.
- R8: In 8-bit mode, an increment from low byte 0xFF wraps the low byte to 0x00, sets the flag and leaves the upper byte unchanged.
- R9: In wide mode the flag is set only on the 0xFFFF to 0x0000 step. The 0x00FF to 0x0100 step does not set it.
- R10: Writing address 3 with bit 0 at 0 clears the flag, and writing bit 0 at 1 has no effect. A rollover in the same cycle as a clear leaves the flag set.
- R11: With the run bit clear, the count holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 1 | External count input, asynchronous |
| bus_sel | input | 2 | Register address: 0 count low, 1 holding, 2 control, 3 flag |
| bus_wr | input | 1 | Write strobe for one clock |
| bus_rd | input | 1 | Read access strobe (triggers the holding-register capture) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register, combinational |
| ovf_flag | output | 1 | Overflow flag |

## Verification
A rollover increment and a software clear of the flag can land on the same clock edge. The bench provokes this in external mode: it preloads the low byte with 0xFF and raises the pin so that the synchronized edge reaches the counter exactly two clocks later, and it times a flag-clear write to be captured on that same edge. The flag must read set afterwards and the low byte 0x00. A later uncontested clear must then drop the flag.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
   localparam int DATA_W = 8;
   localparam int PSEL_W = 3;

   typedef enum logic [1:0] {
      A_CNT_LO = 2'd0,
      A_HI_BUF = 2'd1,
      A_CTRL   = 2'd2,
      A_FLAG   = 2'd3
   } tmr_addr_e;

   typedef struct packed {
      logic              run;
      logic              wide;
      logic              ext_src;
      logic              fall_edge;
      logic              bypass;
      logic [PSEL_W-1:0] ratio;
   } tmr_ctrl_t;

   localparam tmr_ctrl_t CTRL_RST = '{run: 1'b1, wide: 1'b0, ext_src: 1'b1,
                                      fall_edge: 1'b0, bypass: 1'b0, ratio: 3'd7};
endpackage

// File: rtl/tmr_evtsrc.sv
`timescale 1ns/1ps
module tmr_evtsrc #(
   parameter int CYC_DIV     = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ext_pin,
   input  logic ext_src_i,
   input  logic fall_edge_i,
   output logic tick_o,
   output logic evt_o
);
   localparam int DIV_W = (CYC_DIV > 1) ? $clog2(CYC_DIV) : 1;
   localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CYC_DIV - 1);

   generate
      if (CYC_DIV < 2) begin : g_bad_div
         $error("tmr_evtsrc: CYC_DIV must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("tmr_evtsrc: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [DIV_W-1:0] div_q;
   logic [SYNC_STAGES:0] sh_q;
   logic rise_c, fall_c, ext_pulse;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                div_q <= '0;
      else if (div_q == DIV_LAST) div_q <= '0;
      else                       div_q <= div_q + 1'b1;
   end

   assign tick_o = (div_q == DIV_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[SYNC_STAGES-1:0], ext_pin};
   end

   assign rise_c    = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
   assign fall_c    = ~sh_q[SYNC_STAGES-1] & sh_q[SYNC_STAGES];
   assign ext_pulse = fall_edge_i ? fall_c : rise_c;
   assign evt_o     = ext_src_i ? ext_pulse : tick_o;

   // R2
   tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |=> !tick_o);
   // R4
   ext_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_c || fall_c) |=> !(rise_c || fall_c));
endmodule

// File: rtl/tmr_gate_psc.sv
`timescale 1ns/1ps
module tmr_gate_psc #(
   parameter int PSEL_W        = 3,
   parameter int INHIBIT_TICKS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              evt_i,
   input  logic              tick_i,
   input  logic              run_i,
   input  logic              cnt_wr_i,
   input  logic              bypass_i,
   input  logic [PSEL_W-1:0] ratio_i,
   output logic              inc_o
);
   localparam int PS_W = 1 << PSEL_W;
   localparam int IH_W = $clog2(INHIBIT_TICKS + 1);

   generate
      if (PSEL_W < 1 || PSEL_W > 4) begin : g_bad_psel
         $error("tmr_gate_psc: PSEL_W must lie in 1..4");
      end
      if (INHIBIT_TICKS < 1) begin : g_bad_inh
         $error("tmr_gate_psc: INHIBIT_TICKS must be at least 1");
      end
   endgenerate

   logic [IH_W-1:0] inh_q;
   logic [PS_W-1:0] psc_q, term_c;
   logic            gated, psc_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       inh_q <= '0;
      else if (cnt_wr_i)                inh_q <= IH_W'(INHIBIT_TICKS);
      else if (tick_i && inh_q != '0)   inh_q <= inh_q - 1'b1;
   end

   assign gated  = evt_i & run_i & ~cnt_wr_i & (inh_q == '0);
   assign term_c = ({{(PS_W-1){1'b0}}, 1'b1} << ({1'b0, ratio_i} + 1'b1)) - 1'b1;
   assign psc_hit = gated && (psc_q == term_c);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        psc_q <= '0;
      else if (cnt_wr_i) psc_q <= '0;
      else if (gated)    psc_q <= psc_hit ? '0 : psc_q + 1'b1;
   end

   assign inc_o = bypass_i ? gated : psc_hit;

   // R5
   wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr_i |=> !inc_o);
   // R3
   psc_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_o && !bypass_i) |=> !(inc_o && !bypass_i));
endmodule

// File: rtl/tmr_core.sv
`timescale 1ns/1ps
module tmr_core #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wide_i,
   input  logic          inc_i,
   input  logic          cnt_wr_i,
   input  logic          buf_wr_i,
   input  logic          lo_rd_i,
   input  logic          flag_clr_i,
   input  logic [DW-1:0] wdata_i,
   output logic [DW-1:0] cnt_lo_o,
   output logic [DW-1:0] hibuf_o,
   output logic          flag_o
);
   localparam int CW = 2 * DW;

   generate
      if (DW < 2) begin : g_bad_dw
         $error("tmr_core: DW must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt_q;
   logic [DW-1:0] buf_q;
   logic          flag_q, at_top, ovf_set;

   assign at_top  = wide_i ? (cnt_q == '1) : (cnt_q[DW-1:0] == '1);
   assign ovf_set = inc_i && !cnt_wr_i && at_top;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else if (cnt_wr_i) begin
         if (wide_i) cnt_q <= {buf_q, wdata_i};
         else        cnt_q <= {cnt_q[CW-1:DW], wdata_i};
      end else if (inc_i) begin
         if (wide_i) cnt_q <= cnt_q + 1'b1;
         else        cnt_q <= {cnt_q[CW-1:DW], cnt_q[DW-1:0] + 1'b1};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  buf_q <= '0;
      else if (buf_wr_i)           buf_q <= wdata_i;
      else if (lo_rd_i && wide_i)  buf_q <= cnt_q[CW-1:DW];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flag_q <= 1'b0;
      else if (ovf_set)    flag_q <= 1'b1;
      else if (flag_clr_i) flag_q <= 1'b0;
   end

   assign cnt_lo_o = cnt_q[DW-1:0];
   assign hibuf_o  = buf_q;
   assign flag_o   = flag_q;

   // R8
   wrap8_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i && !cnt_wr_i && !wide_i && cnt_q[DW-1:0] == '1)
      |=> (flag_q && cnt_q[DW-1:0] == '0 && $stable(cnt_q[CW-1:DW])));
   // R9
   wrap16_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i && !cnt_wr_i && wide_i && cnt_q == '1) |=> (flag_q && cnt_q == '0));
   // R10
   flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr_i && !inc_i) |=> !flag_q);
   // R6
   capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_rd_i && wide_i && !buf_wr_i) |=> (buf_q == $past(cnt_q[CW-1:DW])));
   // R7
   commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_wr_i && wide_i) |=> (cnt_q == {$past(buf_q), $past(wdata_i)}));
endmodule

// File: rtl/tmr_unit.sv
`timescale 1ns/1ps
module tmr_unit
   import tmr_pkg::*;
#(
   parameter int CYC_DIV       = 4,
   parameter int SYNC_STAGES   = 2,
   parameter int INHIBIT_TICKS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ext_pin,
   input  logic [1:0]        bus_sel,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              ovf_flag
);
   tmr_ctrl_t        ctrl_q;
   tmr_addr_e        addr;
   logic             cnt_wr, buf_wr, ctrl_wr, flag_clr, lo_rd;
   logic             tick, evt, inc;
   logic [DATA_W-1:0] cnt_lo, hibuf;
   logic             flag;

   assign addr     = tmr_addr_e'(bus_sel);
   assign cnt_wr   = bus_wr && addr == A_CNT_LO;
   assign buf_wr   = bus_wr && addr == A_HI_BUF;
   assign ctrl_wr  = bus_wr && addr == A_CTRL;
   assign flag_clr = bus_wr && addr == A_FLAG && !bus_wdata[0];
   assign lo_rd    = bus_rd && !bus_wr && addr == A_CNT_LO;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= CTRL_RST;
      else if (ctrl_wr) ctrl_q <= tmr_ctrl_t'(bus_wdata);
   end

   tmr_evtsrc #(.CYC_DIV(CYC_DIV), .SYNC_STAGES(SYNC_STAGES)) u_src (
      .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin),
      .ext_src_i(ctrl_q.ext_src), .fall_edge_i(ctrl_q.fall_edge),
      .tick_o(tick), .evt_o(evt));

   tmr_gate_psc #(.PSEL_W(PSEL_W), .INHIBIT_TICKS(INHIBIT_TICKS)) u_psc (
      .clk(clk), .rst_n(rst_n), .evt_i(evt), .tick_i(tick),
      .run_i(ctrl_q.run), .cnt_wr_i(cnt_wr), .bypass_i(ctrl_q.bypass),
      .ratio_i(ctrl_q.ratio), .inc_o(inc));

   tmr_core #(.DW(DATA_W)) u_core (
      .clk(clk), .rst_n(rst_n), .wide_i(ctrl_q.wide), .inc_i(inc),
      .cnt_wr_i(cnt_wr), .buf_wr_i(buf_wr), .lo_rd_i(lo_rd),
      .flag_clr_i(flag_clr), .wdata_i(bus_wdata),
      .cnt_lo_o(cnt_lo), .hibuf_o(hibuf), .flag_o(flag));

   always_comb begin
      case (addr)
         A_CNT_LO: bus_rdata = cnt_lo;
         A_HI_BUF: bus_rdata = hibuf;
         A_CTRL:   bus_rdata = ctrl_q;
         default:  bus_rdata = {{(DATA_W-1){1'b0}}, flag};
      endcase
   end

   assign ovf_flag = flag;

   // R11
   halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q.run && !cnt_wr) |=> $stable(cnt_lo));
endmodule

// File: tb/sim_tmr_unit.sv
`timescale 1ns/1ps
module sim_tmr_unit;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ext_pin = 1'b0;
   logic [1:0] bus_sel = 2'd0;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       ovf_flag;

   int n_chk = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   tmr_unit u0 (.clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .bus_sel(bus_sel),
                .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
                .bus_rdata(bus_rdata), .ovf_flag(ovf_flag));

   // {control, start low, ticks waited after the write, expected low, tag code}
   localparam logic [39:0] VEC [10] = '{
      {8'h88, 8'h10, 8'd10, 8'h18, 8'd2},
      {8'h80, 8'h20, 8'd10, 8'h24, 8'd3},
      {8'h81, 8'h30, 8'd18, 8'h34, 8'd3},
      {8'h82, 8'h00, 8'd34, 8'h04, 8'd3},
      {8'h88, 8'h55, 8'd2,  8'h55, 8'd5},
      {8'h88, 8'h55, 8'd3,  8'h56, 8'd5},
      {8'h08, 8'h40, 8'd10, 8'h40, 8'd11},
      {8'h80, 8'h77, 8'd3,  8'h77, 8'd5},
      {8'h81, 8'h00, 8'd4,  8'h00, 8'd3},
      {8'h81, 8'h00, 8'd4,  8'h00, 8'd5}
   };

   function automatic string tag_of(input logic [7:0] c);
      case (c)
         8'd2:    return "R2";
         8'd3:    return "R3";
         8'd5:    return "R5";
         default: return "R11";
      endcase
   endfunction

   task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %02h expected %02h", req, got, exp);
      end
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_sel = a; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [1:0] a, input logic cap, output logic [7:0] d);
      @(negedge clk);
      bus_sel = a; bus_rd = cap;
      #1 d = bus_rdata;
      @(posedge clk);
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic pin_hold(input logic v, input int n);
      @(negedge clk);
      ext_pin = v;
      repeat (n) @(posedge clk);
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (40000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      logic [7:0] d;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset state
      bus_read(2'd2, 1'b0, d); chk("R1 ctrl", d, 8'hA7);
      bus_read(2'd0, 1'b0, d); chk("R1 low", d, 8'h00);
      bus_read(2'd1, 1'b0, d); chk("R1 hold", d, 8'h00);
      bus_read(2'd3, 1'b0, d); chk("R1 flag", d, 8'h00);
      chk("R1 ovf pin", {7'd0, ovf_flag}, 8'h00);

      // table walk: internal source, 8-bit mode
      for (int i = 0; i < 10; i++) begin
         bus_write(2'd2, VEC[i][39:32]);
         bus_write(2'd0, VEC[i][31:24]);
         repeat (4 * int'(VEC[i][23:16])) @(posedge clk);
         #2 chk(tag_of(VEC[i][7:0]), bus_rdata, VEC[i][15:8]);
      end

      // R7 / R6: wide mode, frozen
      bus_write(2'd2, 8'h48);
      bus_write(2'd1, 8'h12);
      bus_read(2'd0, 1'b0, d); chk("R7 hold write leaves low", d, 8'h00);
      bus_write(2'd0, 8'h34);
      bus_write(2'd1, 8'h99);
      bus_read(2'd1, 1'b0, d); chk("R7 hold reg", d, 8'h99);
      bus_read(2'd0, 1'b1, d); chk("R7 low", d, 8'h34);
      bus_read(2'd1, 1'b0, d); chk("R6 captured high", d, 8'h12);

      // R9: 0xFFFE -> 0xFFFF -> 0x0000
      bus_write(2'd2, 8'hC8);
      bus_write(2'd1, 8'hFF);
      bus_write(2'd0, 8'hFE);
      repeat (12) @(posedge clk);
      #2 chk("R9 low FF", bus_rdata, 8'hFF);
      chk("R9 no flag at FFFF", {7'd0, ovf_flag}, 8'h00);
      repeat (4) @(posedge clk);
      #2 chk("R9 wrap low", bus_rdata, 8'h00);
      chk("R9 flag at wrap", {7'd0, ovf_flag}, 8'h01);
      bus_write(2'd2, 8'h48);
      bus_read(2'd0, 1'b1, d);
      bus_read(2'd1, 1'b0, d); chk("R9 high wrapped", d, 8'h00);

      // R9: 0x00FF -> 0x0100 no flag
      bus_write(2'd3, 8'h00);
      bus_write(2'd2, 8'hC8);
      bus_write(2'd1, 8'h00);
      bus_write(2'd0, 8'hFF);
      repeat (12) @(posedge clk);
      #2 chk("R9 low 00", bus_rdata, 8'h00);
      chk("R9 no flag at 0100", {7'd0, ovf_flag}, 8'h00);
      bus_write(2'd2, 8'h48);
      bus_read(2'd0, 1'b1, d);
      bus_read(2'd1, 1'b0, d); chk("R9 high carry", d, 8'h01);

      // preset upper byte to 0x5A for the R8 check
      bus_write(2'd1, 8'h5A);
      bus_write(2'd0, 8'h00);

      // R4 rising edges, 8-bit external, bypass
      bus_write(2'd2, 8'hA8);
      bus_write(2'd0, 8'h00);
      repeat (12) @(posedge clk);
      pin_hold(1'b1, 4); pin_hold(1'b0, 4); pin_hold(1'b1, 6);
      bus_read(2'd0, 1'b0, d); chk("R4 rising", d, 8'h02);

      // R4 falling edges
      bus_write(2'd2, 8'hB8);
      bus_write(2'd0, 8'h00);
      repeat (12) @(posedge clk);
      pin_hold(1'b0, 4); pin_hold(1'b1, 4); pin_hold(1'b0, 4); pin_hold(1'b1, 6);
      bus_read(2'd0, 1'b0, d); chk("R4 falling", d, 8'h02);

      // R8 8-bit rollover
      bus_write(2'd2, 8'hA8);
      pin_hold(1'b0, 6);
      bus_write(2'd0, 8'hFF);
      repeat (12) @(posedge clk);
      pin_hold(1'b1, 4); pin_hold(1'b0, 4);
      bus_read(2'd0, 1'b0, d); chk("R8 low wrap", d, 8'h00);
      chk("R8 flag", {7'd0, ovf_flag}, 8'h01);

      // R10 rollover and clear on the same edge
      bus_write(2'd0, 8'hFF);
      repeat (12) @(posedge clk);
      @(negedge clk) ext_pin = 1'b1;
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      bus_sel = 2'd3; bus_wdata = 8'h00; bus_wr = 1'b1;
      @(posedge clk);
      @(negedge clk) bus_wr = 1'b0;
      #1 chk("R10 set beats clear", {7'd0, ovf_flag}, 8'h01);
      bus_read(2'd0, 1'b0, d); chk("R10 low at collision", d, 8'h00);
      pin_hold(1'b0, 6);
      bus_write(2'd3, 8'h00);
      bus_read(2'd3, 1'b0, d); chk("R10 cleared", d, 8'h00);
      bus_write(2'd3, 8'h01);
      bus_read(2'd3, 1'b0, d); chk("R10 write one ignored", d, 8'h00);

      // R8 upper byte untouched by 8-bit wraps
      bus_write(2'd2, 8'h48);
      bus_read(2'd0, 1'b1, d);
      bus_read(2'd1, 1'b0, d); chk("R8 upper kept", d, 8'h5A);

      // R11 halted external counting
      bus_write(2'd2, 8'h28);
      bus_write(2'd0, 8'h07);
      repeat (12) @(posedge clk);
      pin_hold(1'b1, 4); pin_hold(1'b0, 6);
      bus_read(2'd0, 1'b0, d); chk("R11 halted", d, 8'h07);

      finish_run();
   end
endmodule